// File: doc/BRIEF.md
# Write-Protected Watchdog Timer Controller

This block is a watchdog timer that software drives through a small synchronous register bus with 16-bit data. A guard register holds a single unlock bit. A configuration register holds the watchdog enable, the backup-battery enable, the battery charge enable and a two-bit period code. Writes to the configuration register are dropped while the guard bit is clear. The one exception is the restart bit, which always takes effect. Software therefore has to open the guard on purpose before it can change the setup, and a runaway program is unlikely to reprogram the watchdog by accident.

A prescaler divides the system clock, whose rate is given by the `CLK_HZ` parameter, into a tick every eighth of a second. The watchdog counts these ticks against one of four fixed real-time periods. If the selected period elapses without a restart, the watchdog raises a sticky timed-out flag. Software reads the flag back through the guard register, and the block also drives it on a dedicated output pin.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the guard bit, watchdog enable, backup-battery enable, charge enable, period code and timed-out flag are all zero. A read of the guard register (0x88) or of the status address (0x92) returns 0x0000.
- R2: A write to 0x88 copies data bit 15 into the guard bit. A read of 0x88 returns the guard bit in bit 15.
- R3: While the guard bit is zero, a write to the configuration address (0x90) leaves the watchdog enable, backup-battery enable, charge enable and period code unchanged.
- R4: While the guard bit is one, a write to 0x90 loads the charge enable from bit 14, the backup-battery enable from bit 3, the watchdog enable from bit 2 and the period code from bits 1:0. A read of 0x92 returns the backup-battery enable in bit 3, the watchdog enable in bit 2 and the period code in bits 1:0. The charge enable is not read back.
- R5: The period codes 00, 01, 10 and 11 select 1, 4, 8 and 80 ticks, which is 1/8 s, 1/2 s, 1 s and 10 s. One tick lasts CLK_HZ/8 clock cycles. The flag rises exactly on the clock edge that ends the period, counted from the edge that started the count.
- R6: The timed-out flag is sticky. It stays set until a restart or a reset. A read of 0x88 returns the flag in bit 14, and the `wdTimeout` pin shows the flag.
- R7: A write to 0x90 with bit 15 set clears the flag and restarts the count from zero, whatever the state of the guard bit.
- R8: While the watchdog enable is zero, the count stays at its start value and the flag never rises. Once the watchdog is enabled, a full period runs from that point.
- R9: A write that the guard allows, and that changes the period code while the watchdog is enabled, restarts the count from zero.
- R10: Read data is registered and appears one cycle after the address is presented. Bits with no defined meaning, and reads of any other address (including 0x90), return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Registered read data |
| wdTimeout | output | 1 | Sticky timed-out flag |
| wdEnable | output | 1 | Watchdog enable state |
| backupEn | output | 1 | Backup-battery enable state |
| chargeEn | output | 1 | Battery charge enable state |

## Verification
The bench builds the block with `CLK_HZ` set to 64, so one tick lasts eight cycles. At that rate even the 10-second period runs in 640 cycles, and the bench can exercise all four periods edge-exactly within a short run. The same setting places a restart in the middle of a count a few dozen cycles from its end, which shows whether the count actually went back to zero.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  typedef enum logic [1:0] {
    PER_EIGHTH = 2'b00,
    PER_HALF   = 2'b01,
    PER_ONE    = 2'b10,
    PER_TEN    = 2'b11
  } wdPeriod_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearHit;  // restart request, lock-independent
    logic restart;   // accepted period change while running
  } wdStrobe_t;

  localparam int GUARD_BIT  = 15;
  localparam int FLAG_BIT   = 14;
  localparam int CLEAR_BIT  = 15;
  localparam int CHARGE_BIT = 14;
  localparam int BACKUP_BIT = 3;
  localparam int ENABLE_BIT = 2;
  localparam int TICK_HZ    = 8;
  localparam int MAX_TICKS  = 80;

  function automatic int periodTicks(wdPeriod_t p);
    case (p)
      PER_EIGHTH: return 1;
      PER_HALF:   return 4;
      PER_ONE:    return 8;
      default:    return MAX_TICKS;
    endcase
  endfunction

endpackage

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] GUARD_ADDR  = 8'h88,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h90,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h92
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timedOut,
  output wdStrobe_t         strobe,
  output logic              writeOk,
  output logic              wdEnable,
  output logic              backupEn,
  output logic              chargeEn,
  output wdPeriod_t         periodSel,
  output logic [DATA_W-1:0] rdData
);

  logic guardHit;
  logic cfgHit;
  logic cfgAccept;
  wdPeriod_t newPeriod;
  logic [DATA_W-1:0] rdNext;
  logic unusedBits;

  assign guardHit  = wrEn && (addr == GUARD_ADDR);
  assign cfgHit    = wrEn && (addr == CFG_ADDR);
  assign cfgAccept = cfgHit && writeOk;
  assign newPeriod = wdPeriod_t'(wrData[1:0]);
  assign unusedBits = ^wrData[CHARGE_BIT-1:BACKUP_BIT+1];

  always_comb begin
    strobe          = '0;
    strobe.clearHit = cfgHit && wrData[CLEAR_BIT];
    strobe.restart  = cfgAccept && wdEnable && (newPeriod != periodSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeOk   <= 1'b0;
      wdEnable  <= 1'b0;
      backupEn  <= 1'b0;
      chargeEn  <= 1'b0;
      periodSel <= PER_EIGHTH;
    end else begin
      if (guardHit) writeOk <= wrData[GUARD_BIT];
      if (cfgAccept) begin
        chargeEn  <= wrData[CHARGE_BIT];
        backupEn  <= wrData[BACKUP_BIT];
        wdEnable  <= wrData[ENABLE_BIT];
        periodSel <= newPeriod;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (addr == GUARD_ADDR) begin
      rdNext[GUARD_BIT] = writeOk;
      rdNext[FLAG_BIT]  = timedOut;
    end else if (addr == STATUS_ADDR) begin
      rdNext[BACKUP_BIT] = backupEn;
      rdNext[ENABLE_BIT] = wdEnable;
      rdNext[1:0]        = periodSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/wdt_guard_dp.sv
module wdt_guard_dp
  import wdt_guard_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStrobe_t strobe,
  input  logic      wdEnable,
  input  wdPeriod_t periodSel,
  output logic      timedOut
);

  localparam int DIV   = (CLK_HZ / TICK_HZ > 1) ? CLK_HZ / TICK_HZ : 1;
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic tick;
  logic holdZero;
  logic fire;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] limitM1;

  assign holdZero = !wdEnable || timedOut || strobe.clearHit || strobe.restart;
  assign limitM1  = CNT_W'(periodTicks(periodSel) - 1);
  assign fire     = !holdZero && tick && (elapsed == limitM1);

  generate
    if (DIV > 1) begin : g_prescale
      localparam int PRE_W = $clog2(DIV);
      logic [PRE_W-1:0] pre;
      assign tick = (pre == PRE_W'(DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN || holdZero || tick) pre <= '0;
        else                           pre <= pre + 1'b1;
      end
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsed  <= '0;
      timedOut <= 1'b0;
    end else begin
      if (strobe.clearHit) timedOut <= 1'b0;
      else if (fire)       timedOut <= 1'b1;
      if (holdZero)        elapsed <= '0;
      else if (tick)       elapsed <= elapsed + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GUARD_ADDR  = 8'h88,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h90,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h92
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  output logic              wdTimeout,
  output logic              wdEnable,
  output logic              backupEn,
  output logic              chargeEn
);

  wdStrobe_t strobe;
  wdPeriod_t periodSel;
  logic      writeOk;

  wdt_guard_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(16),
    .GUARD_ADDR(GUARD_ADDR), .CFG_ADDR(CFG_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(busAddr), .wrEn(busWrEn), .wrData(busWrData),
    .timedOut(wdTimeout), .strobe(strobe), .writeOk(writeOk),
    .wdEnable(wdEnable), .backupEn(backupEn), .chargeEn(chargeEn),
    .periodSel(periodSel), .rdData(busRdData)
  );

  wdt_guard_dp #(.CLK_HZ(CLK_HZ)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdEnable(wdEnable),
    .periodSel(periodSel), .timedOut(wdTimeout)
  );

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GUARD_ADDR  = 8'h88,
  parameter logic [ADDR_W-1:0] CFG_ADDR    = 8'h90,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h92
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [15:0]       busWrData,
  input logic [15:0]       busRdData,
  input logic              wdTimeout,
  input logic              wdEnable,
  input logic              backupEn,
  input logic              chargeEn,
  input logic              writeOk,
  input logic [1:0]        periodBits
);

  logic clrWrite;
  assign clrWrite = busWrEn && (busAddr == CFG_ADDR) && busWrData[15];

  assert_guard_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == GUARD_ADDR) |=> writeOk == $past(busWrData[15]));

  assert_locked_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == CFG_ADDR) && !writeOk |=>
      $stable(wdEnable) && $stable(backupEn) && $stable(chargeEn) && $stable(periodBits));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout && !clrWrite |=> wdTimeout);

  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> !wdTimeout);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable && !wdTimeout |=> !wdTimeout);

  assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != GUARD_ADDR) && (busAddr != STATUS_ADDR) |=> busRdData == 16'h0000);

endmodule

bind wdt_guard wdt_guard_chk #(
  .ADDR_W(ADDR_W), .GUARD_ADDR(GUARD_ADDR), .CFG_ADDR(CFG_ADDR), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .wdTimeout(wdTimeout),
  .wdEnable(wdEnable), .backupEn(backupEn), .chargeEn(chargeEn),
  .writeOk(writeOk), .periodBits(periodSel)
);

// File: tb/wdt_guard_test.sv
module wdt_guard_test;

  localparam int CLK_HZ = 64;
  localparam int TICK   = CLK_HZ / 8;
  localparam logic [7:0] A_GUARD  = 8'h88;
  localparam logic [7:0] A_CFG    = 8'h90;
  localparam logic [7:0] A_STATUS = 8'h92;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic busWrEn = 1'b0;
  logic [15:0] busWrData = 16'h0000;
  logic [15:0] busRdData;
  logic wdTimeout, wdEnable, backupEn, chargeEn;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] expVal;
    string       tag;
  } rdItem_t;
  rdItem_t expQ[$];

  always #2 clk = ~clk;

  wdt_guard #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .wdTimeout(wdTimeout),
    .wdEnable(wdEnable), .backupEn(backupEn), .chargeEn(chargeEn)
  );

  // monitor: compares registered read data against queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      rdItem_t it;
      it = expQ.pop_front();
      checks++;
      if (busRdData !== it.expVal) begin
        errors++;
        $display("FAIL %s: read data %h expected %h", it.tag, busRdData, it.expVal);
      end
    end
  end

  task automatic chk(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, expv);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [15:0] e, input string tag);
    rdItem_t it;
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    @(posedge clk);
    it.expVal = e; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // called right after a write edge that starts a count of nTicks
  task automatic window(input int nTicks, input string tag);
    repeat (nTicks * TICK - 1) @(posedge clk);
    #1 chk(wdTimeout, 1'b0, {tag, " before period end"});
    @(posedge clk);
    #1 chk(wdTimeout, 1'b1, {tag, " at period end"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    chk(wdTimeout, 1'b0, "R1 flag");
    chk(chargeEn, 1'b0, "R1 charge");
    chk(backupEn, 1'b0, "R1 backup");
    chk(wdEnable, 1'b0, "R1 enable");
    busRead(A_GUARD, 16'h0000, "R1 guard read");
    busRead(A_STATUS, 16'h0000, "R1 status read");

    // R3 locked write dropped
    busWrite(A_CFG, 16'h400F);
    busRead(A_STATUS, 16'h0000, "R3 status after locked write");
    chk(chargeEn, 1'b0, "R3 charge");
    chk(wdEnable, 1'b0, "R3 enable");

    // R2 unlock
    busWrite(A_GUARD, 16'h8000);
    busRead(A_GUARD, 16'h8000, "R2 guard readback");

    // R4 accepted write, readback layout
    busWrite(A_CFG, 16'h400A);
    busRead(A_STATUS, 16'h000A, "R4 status readback");
    chk(chargeEn, 1'b1, "R4 charge");
    chk(backupEn, 1'b1, "R4 backup");
    busRead(A_CFG, 16'h0000, "R10 write-only address");
    busRead(8'h44, 16'h0000, "R10 unmapped address");

    // R8 disabled never times out
    repeat (200) @(posedge clk);
    #1 chk(wdTimeout, 1'b0, "R8 disabled idle");

    // R5 1/8 s period
    busWrite(A_CFG, 16'h400C);
    window(1, "R5 code 00");
    busRead(A_GUARD, 16'hC000, "R6 flag in guard read");
    repeat (50) @(posedge clk);
    #1 chk(wdTimeout, 1'b1, "R6 sticky");

    // R7 clear works while locked; R3 other bits dropped
    busWrite(A_GUARD, 16'h0000);
    busWrite(A_CFG, 16'h8000);
    chk(wdTimeout, 1'b0, "R7 cleared while locked");
    window(1, "R7 restart from zero");
    busRead(A_STATUS, 16'h000C, "R3 clear write left config");

    // R5 remaining periods
    busWrite(A_GUARD, 16'h8000);
    busWrite(A_CFG, 16'hC00D);
    window(4, "R5 code 01");
    busWrite(A_CFG, 16'hC00E);
    window(8, "R5 code 10");
    busWrite(A_CFG, 16'hC00F);
    window(80, "R5 code 11");

    // R9 period change restarts
    busWrite(A_CFG, 16'hC00F);
    repeat (50) @(posedge clk);
    busWrite(A_CFG, 16'h400E);
    window(8, "R9 restart on period change");

    // R8 disable holds start value, enable runs full period
    busWrite(A_CFG, 16'hC008);
    chk(wdTimeout, 1'b0, "R8 cleared with enable off");
    repeat (100) @(posedge clk);
    #1 chk(wdTimeout, 1'b0, "R8 still quiet");
    busWrite(A_CFG, 16'h400C);
    window(1, "R8 full period after enable");

    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule